// File: doc/BRIEF.md
# Serially Configured Lookup Table

This block is a single lookup-table logic element with K selection inputs. It stores 2^K configuration bits in volatile cells and returns the bit picked by the selection vector through an explicit binary tree of 2-to-1 multiplexers. Each level of the tree splits on one selection input, so the tree is a hardware form of Shannon expansion. To make the element compute any Boolean function of its K inputs, load that function's truth table into the cells.

The cells hold nothing useful after reset. A configuration controller streams the truth table in one bit per clock on `cfg_bit` while `cfg_valid` is high, starting with the entry for the all-ones input. Once exactly 2^K bits have arrived, `cfg_done` rises and the registered output starts following the table. A new stream can begin at any time after `cfg_done` is set. Its first bit drops `cfg_done`, and the output then stays at 0 until the new table is complete.

Top module: `cfg_lut`

## Requirements
- R1: While `rst` is high on a rising clock edge, `cfg_done` and `lut_out` are 0 after that edge.
- R2: A bit is loaded only on a rising edge where `cfg_valid` is 1. Cycles where `cfg_valid` is 0 load nothing, whatever `cfg_bit` holds. The first bit of a stream lands in cell 2^K-1 and the last bit in cell 0.
- R3: `cfg_done` rises at the edge that accepts bit number 2^K of a stream, and not earlier. It changes only on edges where `cfg_valid` is 1.
- R4: While `cfg_done` is 0, `lut_out` is 0 one edge later, regardless of `sel`.
- R5: While `cfg_done` is 1, `lut_out` equals the cell at index `sel` one rising edge after `sel` is sampled. The index reads `sel` as an unsigned number with `sel[K-1]` most significant, so `sel[K-1]` drives the root multiplexer.
- R6: Loading the stream 1,0,0,1 into a 2-input table gives the XNOR of the two inputs: output 1 for `sel`=00 and 11, and 0 for 01 and 10.
- R7: A `cfg_valid` beat while `cfg_done` is 1 starts a new stream. That beat counts as bit 1, `cfg_done` falls at the same edge, and after 2^K bits the new table replaces the old one.
- R8: Parameter K sets the table size from 2 to 6 inputs, with 2^K cells and 2^K-1 two-to-one multiplexers. A 4-input table needs 16 bits before `cfg_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration bit strobe |
| cfg_bit | input | 1 | Serial configuration data, all-ones entry first |
| sel | input | K | Lookup input vector, `sel[K-1]` most significant |
| cfg_done | output | 1 | Set once a full table has been loaded |
| lut_out | output | 1 | Registered table output, 0 until loaded |

## Verification
The bound checker watches the handshake on every cycle: reset clearing, `cfg_done` staying put on idle cycles, `cfg_done` rising only after exactly 2^K beats of a stream, the output being forced to 0 while unconfigured, and a beat on a loaded table dropping `cfg_done`. The checker does not model cell contents, so only the bench scenarios can show that a stream lands in the cells in the right order and that the tree decodes `sel` with the right bit at the root. Those scenarios use the XNOR table, an asymmetric single-one table, a reload with a different function, and a 16-entry table.

// File: rtl/lut_pkg.sv
package lut_pkg;
  // Number of storage cells for a table with k selection inputs.
  function automatic int unsigned lut_cells(input int unsigned k);
    return 32'd1 << k;
  endfunction

  // Number of two-to-one multiplexers in the read tree.
  function automatic int unsigned lut_mux_count(input int unsigned k);
    return (32'd1 << k) - 32'd1;
  endfunction

  // Width of a counter that must reach n.
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lut_mux2.sv
module lut_mux2 (
  input  logic a0,
  input  logic a1,
  input  logic s,
  output logic y
);
  assign y = s ? a1 : a0;
endmodule

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int unsigned K = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shift_en,
  input  logic                          shift_bit,
  output logic [lut_pkg::lut_cells(K)-1:0] cells,
  output logic                          loaded
);
  localparam int unsigned N  = lut_pkg::lut_cells(K);
  localparam int unsigned CW = lut_pkg::count_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] beats;

  // Cells carry no reset: the chain maps onto shift-register resources
  // and the output gate in the top hides contents until loaded.
  always_ff @(posedge clk) begin
    if (shift_en) begin
      cells <= {cells[N-2:0], shift_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beats  <= '0;
      loaded <= 1'b0;
    end else if (shift_en) begin
      if (loaded) begin
        beats  <= CW'(1);
        loaded <= 1'b0;
      end else if (beats == LAST) begin
        beats  <= '0;
        loaded <= 1'b1;
      end else begin
        beats  <= beats + CW'(1);
      end
    end
  end
endmodule

// File: rtl/lut_mux_tree.sv
module lut_mux_tree #(
  parameter int unsigned K = 4
) (
  input  logic [lut_pkg::lut_cells(K)-1:0] leaves,
  input  logic [K-1:0]                     sel,
  output logic                             y
);
  localparam int unsigned N = lut_pkg::lut_cells(K);

  // Level l halves the candidate set using sel[l]; the last level is the root.
  for (genvar l = 0; l < K; l++) begin : g_lvl
    localparam int unsigned W = N >> (l + 1);
    logic [2*W-1:0] d;
    logic [W-1:0]   q;
    if (l == 0) begin : g_leaf
      assign d = leaves;
    end else begin : g_inner
      assign d = g_lvl[l-1].q;
    end
    for (genvar j = 0; j < W; j++) begin : g_mux
      lut_mux2 u_mux (
        .a0 (d[2*j]),
        .a1 (d[2*j+1]),
        .s  (sel[l]),
        .y  (q[j])
      );
    end
  end

  assign y = g_lvl[K-1].q[0];
endmodule

// File: rtl/cfg_lut.sv
module cfg_lut #(
  parameter int unsigned K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_valid,
  input  logic         cfg_bit,
  input  logic [K-1:0] sel,
  output logic         cfg_done,
  output logic         lut_out
);
  localparam int unsigned N = lut_pkg::lut_cells(K);

  logic [N-1:0] cells;
  logic         tree_y;

  lut_cfg_chain #(.K(K)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (cfg_valid),
    .shift_bit (cfg_bit),
    .cells     (cells),
    .loaded    (cfg_done)
  );

  lut_mux_tree #(.K(K)) u_tree (
    .leaves (cells),
    .sel    (sel),
    .y      (tree_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_out <= 1'b0;
    end else begin
      lut_out <= cfg_done ? tree_y : 1'b0;
    end
  end
endmodule

// File: rtl/cfg_lut_chk.sv
module cfg_lut_chk #(
  parameter int unsigned K = 4
) (
  input logic clk,
  input logic rst,
  input logic cfg_valid,
  input logic cfg_done,
  input logic lut_out
);
  localparam int unsigned N  = lut_pkg::lut_cells(K);
  localparam int unsigned CW = lut_pkg::count_width(N);

  // Beats seen in the current stream, counted independently of the chain.
  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
    end else if (cfg_valid) begin
      if (cfg_done) seen <= CW'(1);
      else if (seen != CW'(N)) seen <= seen + CW'(1);
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!cfg_done && !lut_out));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |=> $stable(cfg_done));

  p_done_count_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> (seen == CW'(N)));

  p_done_rise_beat_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(cfg_valid));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |=> !lut_out);

  p_reload_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_done) |=> !cfg_done);
endmodule

bind cfg_lut cfg_lut_chk #(.K(K)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_valid (cfg_valid),
  .cfg_done  (cfg_done),
  .lut_out   (lut_out)
);

// File: tb/cfg_lut_test.sv
module cfg_lut_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       v2 = 1'b0, b2 = 1'b0, done2, out2;
  logic [1:0] s2 = '0;
  logic       v4 = 1'b0, b4 = 1'b0, done4, out4;
  logic [3:0] s4 = '0;

  cfg_lut #(.K(2)) uut (
    .clk(clk), .rst(rst), .cfg_valid(v2), .cfg_bit(b2), .sel(s2),
    .cfg_done(done2), .lut_out(out2)
  );

  cfg_lut #(.K(4)) uut_wide (
    .clk(clk), .rst(rst), .cfg_valid(v4), .cfg_bit(b4), .sel(s4),
    .cfg_done(done4), .lut_out(out4)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One configuration beat, driven at the falling edge.
  task automatic feed(input bit wide, input logic b);
    @(negedge clk);
    if (wide) begin v4 = 1'b1; b4 = b; end
    else      begin v2 = 1'b1; b2 = b; end
  endtask

  // One idle cycle with cfg_bit set to noise.
  task automatic idle(input bit wide);
    @(negedge clk);
    if (wide) begin v4 = 1'b0; b4 = 1'b1; end
    else      begin v2 = 1'b0; b2 = 1'b1; end
  endtask

  task automatic load2(input logic [3:0] pat);
    for (int i = 3; i >= 0; i--) feed(1'b0, pat[i]);
    idle(1'b0);
  endtask

  task automatic sweep2(input logic [3:0] pat, input string req);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); s2 = 2'(i);
      @(negedge clk); check(req, {31'd0, out2}, {31'd0, pat[i]});
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done2", {31'd0, done2}, 0);
    check("R1 out2",  {31'd0, out2}, 0);
    check("R1 done4", {31'd0, done4}, 0);
    rst = 1'b0;
  endtask

  // R2 gaps, R3 exact count, R4 gating, R6 XNOR.
  task automatic t_xnor_with_gaps;
    feed(1'b0, 1'b1);
    feed(1'b0, 1'b0);
    idle(1'b0); s2 = 2'b11;
    idle(1'b0);
    idle(1'b0);
    check("R2 idle cycles add no bits", {31'd0, done2}, 0);
    check("R4 output held low", {31'd0, out2}, 0);
    feed(1'b0, 1'b0);
    idle(1'b0);
    check("R3 not done after 3 bits", {31'd0, done2}, 0);
    feed(1'b0, 1'b1);
    idle(1'b0);
    check("R3 done after 4 bits", {31'd0, done2}, 1);
    sweep2(4'b1001, "R6 xnor");
  endtask

  // R2 order and R5 root select: a single one at index 1 (sel=01).
  task automatic t_order;
    load2(4'b0010);
    check("R3 done after reload", {31'd0, done2}, 1);
    sweep2(4'b0010, "R2 R5 bit order");
  endtask

  // R7 reload of a different function.
  task automatic t_reload;
    s2 = 2'b00;
    feed(1'b0, 1'b0);
    idle(1'b0);
    check("R7 first beat drops done", {31'd0, done2}, 0);
    @(negedge clk);
    check("R7 output low during reload", {31'd0, out2}, 0);
    feed(1'b0, 1'b1);
    feed(1'b0, 1'b1);
    feed(1'b0, 1'b0);
    idle(1'b0);
    check("R7 done after new table", {31'd0, done2}, 1);
    sweep2(4'b0110, "R7 xor table");
  endtask

  // R8 sixteen-entry table.
  task automatic t_wide;
    logic [15:0] pat = 16'hA5C3;
    for (int i = 15; i >= 1; i--) feed(1'b1, pat[i]);
    idle(1'b1);
    check("R8 not done after 15 bits", {31'd0, done4}, 0);
    feed(1'b1, pat[0]);
    idle(1'b1);
    check("R8 done after 16 bits", {31'd0, done4}, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); s4 = 4'(i);
      @(negedge clk); check("R8 R5 wide read", {31'd0, out4}, {31'd0, pat[i]});
    end
  endtask

  initial begin
    t_reset();
    t_xnor_with_gaps();
    t_order();
    t_reload();
    t_wide();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule